// File: doc/BRIEF.md
# Pseudo-Random Memory Test Engine

This block is a bus master that exercises a wide external memory through a controller with a ready/valid, burst-oriented memory-mapped interface. A start pulse runs a test in two passes. The write pass fills the memory from address zero up to a programmable limit with pseudo-random words. The read pass rewinds the generators, requests the same range back, and counts every returned word that differs from the regenerated sequence. When the test ends, a done flag is raised, and a pass flag reports whether the error count stayed at zero.

The data word is made of several 64-bit linear feedback shift registers placed side by side, each with its own seed. Three modes change how requests are issued. Random addressing draws transaction start addresses from a separate 26-bit generator; overlapping addresses then produce mismatches, so this mode is only useful for load measurement. Single-outstanding-read mode holds back each read request until every beat of the previous one has come back, which isolates latency. The auto-precharge option flags every request to the controller.

Top module: `memtest_engine`

## Requirements
- R1: The write pass issues transactions at start addresses 0, B, 2B, ... for as long as the start address is below the limit L. Each transaction has B beats with `memWrite` high on every beat, and `memAddress` and `memBurstCount` (= B) are held for all beats of the transaction.
- R2: The write data is DATA_W/64 lanes of 64 bits. Lane i occupies bits [64i+63:64i] and is seeded with DATA_SEED_BASE + i * 0x9E3779B97F4A7C15 (mod 2^64). Each accepted write beat advances every lane once by a left shift that takes in the XOR of state bits 63, 62, 60 and 59 at bit 0. The first beat carries the seeds.
- R3: After the last write beat the generators return to their seeds, and the read pass issues read transactions of B beats over the same start address sequence. The test expects exactly (number of transactions) × B returned words.
- R4: Each word returned with `memReadValid` during the read pass is compared with the next word of the regenerated sequence. Each mismatch adds one to `errorCount`, which saturates at all ones.
- R5: `testDone` rises only after all read requests have been issued and every requested beat has returned. At that point `testPass` is 1 exactly when `errorCount` is 0, and `testPass` is never 1 while `testDone` is 0.
- R6: A request (`memRead` or `memWrite`) that sees `memReady` low is held with unchanged address, burst count and write data until it is accepted.
- R7: With `singleReadEn` set, `memRead` is asserted only when no requested read beat is still outstanding.
- R8: With `randAddrEn` set, the start address of transaction k in each pass is (S_k[ADDR_W-1:0]) AND (L-1). S_0 = 0x3FBF807, and S advances once per accepted transaction by a left shift that takes in the XOR of bits 25, 5, 1 and 0. The generator restarts from its seed for the read pass.
- R9: `memAutoPrecharge` equals the auto-precharge setting latched at start ANDed with (`memRead` OR `memWrite`).
- R10: `startPulse` is accepted only while idle or done. It latches the configuration, clears `testDone`, `testPass` and `errorCount`, and starts the write pass. A pulse during a running test is ignored.
- R11: `clearPulse` aborts any test and returns the engine to idle with `testDone`, `testPass` and `errorCount` at 0 and no requests driven.
- R12: `memReadValid` outside the read pass (idle or done) does not change `errorCount` or `testDone`.
- R13: After reset, `testDone`, `testPass`, `errorCount`, `memRead` and `memWrite` are 0.
- R14: `memRead` and `memWrite` are never high in the same cycle. A `burstCount` of 0 selects B = 4, and an `addrLimit` of 0 selects L = 2^ADDR_W − 2^BURST_W.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Memory-side clock |
| rst | input | 1 | Synchronous active-high reset |
| startPulse | input | 1 | Starts a test when idle or done |
| clearPulse | input | 1 | Aborts and clears the engine |
| burstCount | input | BURST_W | Beats per transaction (0 selects 4) |
| addrLimit | input | ADDR_W | End of the tested range (0 selects default) |
| randAddrEn | input | 1 | Random transaction addressing |
| singleReadEn | input | 1 | At most one read in flight |
| autoPrechargeEn | input | 1 | Request auto precharge on every transaction |
| memReady | input | 1 | Controller accepts the current request |
| memRead | output | 1 | Read request |
| memWrite | output | 1 | Write beat |
| memAddress | output | ADDR_W | Transaction start address in words |
| memBurstCount | output | BURST_W | Beats in the transaction |
| memWriteData | output | DATA_W | Write beat data |
| memReadData | input | DATA_W | Returned read data |
| memReadValid | input | 1 | Returned data is valid |
| memAutoPrecharge | output | 1 | Auto-precharge request |
| testDone | output | 1 | Test finished |
| testPass | output | 1 | Finished with no mismatches |
| errorCount | output | ERR_W | Mismatched words |

## Verification
The hardest state to reach from the ports is the read pass with many beats still in flight while the controller alternately stalls requests and trickles responses. In that state the done point, the single-read gating and the compare order all depend on exact beat accounting. The bench drives `memReady` and the response timing from its own pseudo-random stream. A behavioural memory model queues each requested beat and can corrupt chosen returned words. Random addressing with overlapping writes makes the expected error count come out of the model's own stored data rather than from a fixed number.

// File: rtl/memtest_pkg.sv
package memtest_pkg;

  localparam int LANE_W  = 64;
  localparam int RADDR_W = 26;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WRITE,
    ST_READ,
    ST_WAIT,
    ST_DONE
  } mt_state_e;

  // strobes from control to datapath
  typedef struct packed {
    logic reload;    // return all generators to seed
    logic dataStep;  // advance data lanes
    logic checkBeat; // compare returned word
    logic addrStep;  // advance address generator
    logic clearErr;  // zero the error counter
  } mt_strobe_t;

  function automatic logic [LANE_W-1:0] laneStep(input logic [LANE_W-1:0] s);
    return {s[LANE_W-2:0], s[63] ^ s[62] ^ s[60] ^ s[59]};
  endfunction

  function automatic logic [RADDR_W-1:0] addrGenStep(input logic [RADDR_W-1:0] s);
    return {s[RADDR_W-2:0], s[25] ^ s[5] ^ s[1] ^ s[0]};
  endfunction

endpackage

// File: rtl/memtest_datapath.sv
module memtest_datapath
  import memtest_pkg::*;
#(
  parameter int               DATA_W         = 256,
  parameter int               ADDR_W         = 12,
  parameter int               ERR_W          = 16,
  parameter logic [63:0]      DATA_SEED_BASE = 64'h0123456789ABCDEF,
  parameter logic [RADDR_W-1:0] ADDR_SEED    = 26'h3FBF807
) (
  input  logic              clk,
  input  logic              rst,
  input  mt_strobe_t        strb,
  input  logic [DATA_W-1:0] memReadData,
  output logic [DATA_W-1:0] genWord,
  output logic [ADDR_W-1:0] randAddr,
  output logic [ERR_W-1:0]  errorCount,
  output logic              errZero
);

  localparam int LANES = DATA_W / LANE_W;
  localparam logic [63:0] SEED_STRIDE = 64'h9E3779B97F4A7C15;

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    localparam logic [LANE_W-1:0] LANE_SEED = DATA_SEED_BASE + 64'(i) * SEED_STRIDE;
    logic [LANE_W-1:0] laneState;
    always_ff @(posedge clk) begin
      if (rst || strb.reload) laneState <= LANE_SEED;
      else if (strb.dataStep) laneState <= laneStep(laneState);
    end
    assign genWord[i*LANE_W +: LANE_W] = laneState;
  end

  logic [RADDR_W-1:0] addrState;
  always_ff @(posedge clk) begin
    if (rst || strb.reload) addrState <= ADDR_SEED;
    else if (strb.addrStep) addrState <= addrGenStep(addrState);
  end
  assign randAddr = addrState[ADDR_W-1:0];

  logic mismatch;
  assign mismatch = (memReadData != genWord);

  always_ff @(posedge clk) begin
    if (rst || strb.clearErr) errorCount <= '0;
    else if (strb.checkBeat && mismatch && !(&errorCount)) errorCount <= errorCount + 1'b1;
  end
  assign errZero = (errorCount == '0);

endmodule

// File: rtl/memtest_ctrl.sv
module memtest_ctrl
  import memtest_pkg::*;
#(
  parameter int ADDR_W    = 12,
  parameter int BURST_W   = 4,
  parameter int PEND_W    = 16,
  parameter int DEF_BURST = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               startPulse,
  input  logic               clearPulse,
  input  logic [BURST_W-1:0] burstCount,
  input  logic [ADDR_W-1:0]  addrLimit,
  input  logic               randAddrEn,
  input  logic               singleReadEn,
  input  logic               autoPrechargeEn,
  input  logic               memReady,
  input  logic               memReadValid,
  input  logic [ADDR_W-1:0]  randAddr,
  input  logic               errZero,
  output mt_strobe_t         strb,
  output logic               memRead,
  output logic               memWrite,
  output logic [ADDR_W-1:0]  memAddress,
  output logic [BURST_W-1:0] memBurstCount,
  output logic               memAutoPrecharge,
  output logic               testDone,
  output logic               testPass
);

  localparam logic [ADDR_W-1:0]  DEF_LIMIT = ADDR_W'((1 << ADDR_W) - (1 << BURST_W));
  localparam logic [BURST_W-1:0] DEF_BEATS = BURST_W'(DEF_BURST);

  mt_state_e          state;
  logic [BURST_W-1:0] burstLat, beatIdx;
  logic [ADDR_W-1:0]  limitLat;
  logic [ADDR_W:0]    seqAddr, nextAddr;
  logic [PEND_W-1:0]  pending;
  logic               randLat, singleLat, apLat;

  logic canIssue, wrFire, rdFire, lastBeat, lastTx, checkBeat, startOk;

  always_comb begin
    canIssue  = !singleLat || (pending == '0);
    memWrite  = (state == ST_WRITE);
    memRead   = (state == ST_READ) && canIssue;
    wrFire    = memWrite && memReady;
    rdFire    = memRead && memReady;
    lastBeat  = (beatIdx == burstLat - 1'b1);
    nextAddr  = seqAddr + (ADDR_W+1)'(burstLat);
    lastTx    = (nextAddr >= {1'b0, limitLat});
    checkBeat = memReadValid && ((state == ST_READ) || (state == ST_WAIT));
    startOk   = startPulse && !clearPulse && ((state == ST_IDLE) || (state == ST_DONE));

    strb.reload    = startOk || (wrFire && lastBeat && lastTx);
    strb.dataStep  = wrFire || checkBeat;
    strb.checkBeat = checkBeat;
    strb.addrStep  = (wrFire && lastBeat) || rdFire;
    strb.clearErr  = startOk || clearPulse;

    memAddress       = randLat ? (randAddr & (limitLat - 1'b1)) : seqAddr[ADDR_W-1:0];
    memBurstCount    = burstLat;
    memAutoPrecharge = apLat && (memRead || memWrite);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      burstLat  <= DEF_BEATS;
      limitLat  <= DEF_LIMIT;
      seqAddr   <= '0;
      beatIdx   <= '0;
      pending   <= '0;
      randLat   <= 1'b0;
      singleLat <= 1'b0;
      apLat     <= 1'b0;
      testDone  <= 1'b0;
      testPass  <= 1'b0;
    end else if (clearPulse) begin
      state    <= ST_IDLE;
      pending  <= '0;
      testDone <= 1'b0;
      testPass <= 1'b0;
    end else begin
      pending <= pending + (rdFire ? PEND_W'(burstLat) : '0) - PEND_W'(checkBeat);
      unique case (state)
        ST_IDLE, ST_DONE: begin
          if (startOk) begin
            burstLat  <= (burstCount == '0) ? DEF_BEATS : burstCount;
            limitLat  <= (addrLimit == '0) ? DEF_LIMIT : addrLimit;
            randLat   <= randAddrEn;
            singleLat <= singleReadEn;
            apLat     <= autoPrechargeEn;
            seqAddr   <= '0;
            beatIdx   <= '0;
            testDone  <= 1'b0;
            testPass  <= 1'b0;
            state     <= ST_WRITE;
          end
        end
        ST_WRITE: begin
          if (wrFire) begin
            if (lastBeat) begin
              beatIdx <= '0;
              if (lastTx) begin
                seqAddr <= '0;
                state   <= ST_READ;
              end else begin
                seqAddr <= nextAddr;
              end
            end else begin
              beatIdx <= beatIdx + 1'b1;
            end
          end
        end
        ST_READ: begin
          if (rdFire) begin
            if (lastTx) state <= ST_WAIT;
            else seqAddr <= nextAddr;
          end
        end
        ST_WAIT: begin
          if (pending == '0) begin
            testDone <= 1'b1;
            testPass <= errZero;
            state    <= ST_DONE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/memtest_engine.sv
module memtest_engine
  import memtest_pkg::*;
#(
  parameter int                 DATA_W         = 256,
  parameter int                 ADDR_W         = 12,
  parameter int                 BURST_W        = 4,
  parameter int                 ERR_W          = 16,
  parameter int                 PEND_W         = 16,
  parameter int                 DEF_BURST      = 4,
  parameter logic [63:0]        DATA_SEED_BASE = 64'h0123456789ABCDEF,
  parameter logic [RADDR_W-1:0] ADDR_SEED      = 26'h3FBF807
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               startPulse,
  input  logic               clearPulse,
  input  logic [BURST_W-1:0] burstCount,
  input  logic [ADDR_W-1:0]  addrLimit,
  input  logic               randAddrEn,
  input  logic               singleReadEn,
  input  logic               autoPrechargeEn,
  input  logic               memReady,
  output logic               memRead,
  output logic               memWrite,
  output logic [ADDR_W-1:0]  memAddress,
  output logic [BURST_W-1:0] memBurstCount,
  output logic [DATA_W-1:0]  memWriteData,
  input  logic [DATA_W-1:0]  memReadData,
  input  logic               memReadValid,
  output logic               memAutoPrecharge,
  output logic               testDone,
  output logic               testPass,
  output logic [ERR_W-1:0]   errorCount
);

  mt_strobe_t        strb;
  logic [ADDR_W-1:0] randAddr;
  logic              errZero;

  memtest_ctrl #(
    .ADDR_W(ADDR_W), .BURST_W(BURST_W), .PEND_W(PEND_W), .DEF_BURST(DEF_BURST)
  ) u_ctrl (
    .clk(clk), .rst(rst), .startPulse(startPulse), .clearPulse(clearPulse),
    .burstCount(burstCount), .addrLimit(addrLimit), .randAddrEn(randAddrEn),
    .singleReadEn(singleReadEn), .autoPrechargeEn(autoPrechargeEn),
    .memReady(memReady), .memReadValid(memReadValid), .randAddr(randAddr),
    .errZero(errZero), .strb(strb), .memRead(memRead), .memWrite(memWrite),
    .memAddress(memAddress), .memBurstCount(memBurstCount),
    .memAutoPrecharge(memAutoPrecharge), .testDone(testDone), .testPass(testPass)
  );

  memtest_datapath #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .ERR_W(ERR_W),
    .DATA_SEED_BASE(DATA_SEED_BASE), .ADDR_SEED(ADDR_SEED)
  ) u_dp (
    .clk(clk), .rst(rst), .strb(strb), .memReadData(memReadData),
    .genWord(memWriteData), .randAddr(randAddr), .errorCount(errorCount),
    .errZero(errZero)
  );

endmodule

// File: rtl/memtest_engine_chk.sv
module memtest_engine_chk #(
  parameter int DATA_W  = 256,
  parameter int ADDR_W  = 12,
  parameter int BURST_W = 4,
  parameter int ERR_W   = 16
) (
  input logic               clk,
  input logic               rst,
  input logic               startPulse,
  input logic               clearPulse,
  input logic               singleReadEn,
  input logic               memReady,
  input logic               memRead,
  input logic               memWrite,
  input logic [ADDR_W-1:0]  memAddress,
  input logic [BURST_W-1:0] memBurstCount,
  input logic [DATA_W-1:0]  memWriteData,
  input logic               memReadValid,
  input logic               memAutoPrecharge,
  input logic               testDone,
  input logic               testPass,
  input logic [ERR_W-1:0]   errorCount
);

  // beats requested and not yet returned, seen from the ports only
  int outCnt;
  always_ff @(posedge clk) begin
    if (rst || clearPulse) outCnt <= 0;
    else outCnt <= outCnt + ((memRead && memReady) ? int'(memBurstCount) : 0)
                          - ((memReadValid && outCnt > 0) ? 1 : 0);
  end

  p_no_rw_overlap_r14: assert property (@(posedge clk) disable iff (rst)
    !(memRead && memWrite));

  p_write_hold_r6: assert property (@(posedge clk) disable iff (rst)
    (memWrite && !memReady && !clearPulse) |=>
      (memWrite && $stable(memWriteData) && $stable(memAddress) && $stable(memBurstCount)));

  p_read_hold_r6: assert property (@(posedge clk) disable iff (rst)
    (memRead && !memReady && !clearPulse) |=>
      (memRead && $stable(memAddress) && $stable(memBurstCount)));

  p_single_read_r7: assert property (@(posedge clk) disable iff (rst)
    (singleReadEn && memRead) |-> (outCnt == 0));

  p_ap_gate_r9: assert property (@(posedge clk) disable iff (rst)
    memAutoPrecharge |-> (memRead || memWrite));

  p_pass_needs_done_r5: assert property (@(posedge clk) disable iff (rst)
    testPass |-> testDone);

  p_done_drained_r5: assert property (@(posedge clk) disable iff (rst)
    $rose(testDone) |-> (outCnt == 0));

  p_done_quiet_r5: assert property (@(posedge clk) disable iff (rst)
    testDone |-> (!memRead && !memWrite));

  p_err_monotonic_r4: assert property (@(posedge clk) disable iff (rst)
    (!startPulse && !clearPulse) |=> (errorCount >= $past(errorCount)));

endmodule

bind memtest_engine memtest_engine_chk #(
  .DATA_W(DATA_W), .ADDR_W(ADDR_W), .BURST_W(BURST_W), .ERR_W(ERR_W)
) u_chk (.*);

// File: tb/memtest_engine_tb.sv
module memtest_engine_tb;

  localparam int CLK_PERIOD = 10;
  localparam int DATA_W  = 256;
  localparam int ADDR_W  = 12;
  localparam int BURST_W = 4;
  localparam int ERR_W   = 16;
  localparam int LANES   = DATA_W / 64;
  localparam logic [63:0] SEED_BASE = 64'h0123456789ABCDEF;
  localparam logic [63:0] STRIDE    = 64'h9E3779B97F4A7C15;
  localparam logic [25:0] A_SEED    = 26'h3FBF807;
  localparam int DEF_L = (1 << ADDR_W) - (1 << BURST_W);

  logic clk = 1'b0, rst = 1'b1;
  logic startPulse = 0, clearPulse = 0;
  logic [BURST_W-1:0] burstCount = '0;
  logic [ADDR_W-1:0]  addrLimit = '0;
  logic randAddrEn = 0, singleReadEn = 0, autoPrechargeEn = 0;
  logic memReady = 0, memReadValid = 0;
  logic [DATA_W-1:0] memReadData = '0;
  logic memRead, memWrite, memAutoPrecharge, testDone, testPass;
  logic [ADDR_W-1:0] memAddress;
  logic [BURST_W-1:0] memBurstCount;
  logic [DATA_W-1:0] memWriteData;
  logic [ERR_W-1:0] errorCount;

  memtest_engine #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .BURST_W(BURST_W), .ERR_W(ERR_W)) u_dut (
    .clk(clk), .rst(rst), .startPulse(startPulse), .clearPulse(clearPulse),
    .burstCount(burstCount), .addrLimit(addrLimit), .randAddrEn(randAddrEn),
    .singleReadEn(singleReadEn), .autoPrechargeEn(autoPrechargeEn),
    .memReady(memReady), .memRead(memRead), .memWrite(memWrite),
    .memAddress(memAddress), .memBurstCount(memBurstCount),
    .memWriteData(memWriteData), .memReadData(memReadData),
    .memReadValid(memReadValid), .memAutoPrecharge(memAutoPrecharge),
    .testDone(testDone), .testPass(testPass), .errorCount(errorCount)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0, failures = 0;

  // reference model state
  logic [DATA_W-1:0] store [int];
  logic [DATA_W-1:0] expSeq [$];
  int respQ [$];
  logic [63:0] lane [LANES];
  logic [25:0] a26;
  logic [31:0] lcg = 32'h1234_5678;
  int phase, B, L, nTx, txCnt, wrBeat, outstanding, rdIdx, expErr;
  int flipA, flipB, pokeAt, runCyc;
  bit rndOn, sglOn, apOn, doneSeen;

  function automatic logic [63:0] laneNext(input logic [63:0] s);
    logic fb;
    fb = s[63] ^ s[62] ^ s[60] ^ s[59];
    return (s << 1) | {63'd0, fb};
  endfunction

  function automatic logic [25:0] addrNext(input logic [25:0] s);
    logic fb;
    fb = s[25] ^ s[5] ^ s[1] ^ s[0];
    return (s << 1) | {25'd0, fb};
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [DATA_W-1:0] act,
                     input logic [DATA_W-1:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick();
    int outBefore, txAddr;
    bit expRd;
    logic [DATA_W-1:0] w;
    @(negedge clk);
    runCyc++;
    startPulse = (runCyc == pokeAt);
    lcg = lcg * 32'd1664525 + 32'd1013904223;
    memReady = (lcg[15:14] != 2'b00);
    outBefore = outstanding;
    memReadValid = 1'b0;
    if (respQ.size() > 0 && lcg[20]) begin
      int a;
      a = respQ.pop_front();
      w = store.exists(a) ? store[a] : '0;
      if (rdIdx == flipA || rdIdx == flipB) w[0] = ~w[0];
      memReadData = w;
      memReadValid = 1'b1;
      if (rdIdx >= expSeq.size() || w != expSeq[rdIdx]) expErr++;
      rdIdx++;
      outstanding--;
    end
    #1;
    chk(!(memRead && memWrite), "R14 read and write overlap", {memRead, memWrite}, 0);
    chk(memAutoPrecharge == (apOn && (memRead || memWrite)), "R9 auto precharge",
        memAutoPrecharge, apOn && (memRead || memWrite));
    chk(memWrite == (phase == 1), "R1 write strobe", memWrite, phase == 1);
    expRd = (phase == 2) && (txCnt < nTx) && (!sglOn || outBefore == 0);
    chk(memRead == expRd, sglOn ? "R7 single read gating" : "R3 read request", memRead, expRd);
    txAddr = rndOn ? (int'(a26[ADDR_W-1:0]) & (L - 1)) : txCnt * B;
    if (memWrite && memReady && phase == 1) begin
      for (int i = 0; i < LANES; i++) w[i*64 +: 64] = lane[i];
      chk(memWriteData == w, "R2 write data", memWriteData, w);
      chk(memAddress == ADDR_W'(txAddr), rndOn ? "R8 write address" : "R1 write address",
          memAddress, txAddr);
      chk(memBurstCount == BURST_W'(B), "R1 burst count", memBurstCount, B);
      store[txAddr + wrBeat] = w;
      expSeq.push_back(w);
      for (int i = 0; i < LANES; i++) lane[i] = laneNext(lane[i]);
      wrBeat++;
      if (wrBeat == B) begin
        wrBeat = 0;
        txCnt++;
        a26 = addrNext(a26);
        if (txCnt == nTx) begin
          phase = 2;
          txCnt = 0;
          a26 = A_SEED;
        end
      end
    end
    if (memRead && memReady && phase == 2) begin
      chk(memAddress == ADDR_W'(txAddr), rndOn ? "R8 read address" : "R3 read address",
          memAddress, txAddr);
      chk(memBurstCount == BURST_W'(B), "R3 read burst count", memBurstCount, B);
      for (int i = 0; i < B; i++) respQ.push_back(txAddr + i);
      outstanding += B;
      txCnt++;
      a26 = addrNext(a26);
    end
    if (testDone && !doneSeen) begin
      doneSeen = 1;
      chk(outstanding == 0 && respQ.size() == 0 && phase == 2 && txCnt == nTx,
          "R5 done only after drain", outstanding, 0);
    end
  endtask

  task automatic startTest(input int bc, input int lim, input bit rnd, input bit sgl,
                           input bit ap, input int fa, input int fb, input int poke);
    @(negedge clk);
    burstCount = BURST_W'(bc);
    addrLimit = ADDR_W'(lim);
    randAddrEn = rnd; singleReadEn = sgl; autoPrechargeEn = ap;
    startPulse = 1'b1;
    memReadValid = 1'b0;
    B = (bc == 0) ? 4 : bc;
    L = (lim == 0) ? DEF_L : lim;
    nTx = (L + B - 1) / B;
    rndOn = rnd; sglOn = sgl; apOn = ap;
    for (int i = 0; i < LANES; i++) lane[i] = SEED_BASE + 64'(i) * STRIDE;
    a26 = A_SEED;
    expSeq.delete();
    respQ.delete();
    phase = 1; txCnt = 0; wrBeat = 0; outstanding = 0; rdIdx = 0; expErr = 0;
    flipA = fa; flipB = fb; pokeAt = poke; runCyc = 0; doneSeen = 0;
  endtask

  task automatic runTest(input string name, input int bc, input int lim, input bit rnd,
                         input bit sgl, input bit ap, input int fa, input int fb, input int poke);
    int expCnt;
    startTest(bc, lim, rnd, sgl, ap, fa, fb, poke);
    while (!doneSeen && runCyc < 60000) tick();
    if (!doneSeen) begin
      failures++;
      $display("FAIL R5 %s never finished actual=running expected=done", name);
    end
    expCnt = (expErr > 65535) ? 65535 : expErr;
    chk(rdIdx == nTx * B, "R3 returned word count", rdIdx, nTx * B);
    chk(errorCount == ERR_W'(expCnt), "R4 error count", errorCount, expCnt);
    chk(testPass == (expErr == 0), "R5 pass flag", testPass, expErr == 0);
    phase = 0;
    startPulse = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    failures++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    phase = 0; rndOn = 0; sglOn = 0; apOn = 0; pokeAt = -1; flipA = -1; flipB = -1;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    #1;
    chk(!testDone && !testPass && errorCount == 0, "R13 reset flags", {testDone, testPass, errorCount}, 0);
    chk(!memRead && !memWrite, "R13 reset requests", {memRead, memWrite}, 0);

    // sequential, clean
    runTest("seq_b4", 4, 64, 0, 0, 0, -1, -1, -1);
    // single beats, two corrupted words; restart from done (R10)
    runTest("seq_b1_faults", 1, 32, 0, 0, 0, 3, 17, -1);
    chk(errorCount == 2, "R4 injected mismatches", errorCount, 2);

    // stray read data while done is ignored
    repeat (3) begin
      @(negedge clk);
      memReadValid = 1'b1;
      memReadData = {8{lcg}};
    end
    @(negedge clk);
    memReadValid = 1'b0;
    #1;
    chk(errorCount == 2 && testDone, "R12 stray valid ignored", errorCount, 2);

    // clear after done
    @(negedge clk); clearPulse = 1'b1;
    @(negedge clk); clearPulse = 1'b0;
    #1;
    chk(!testDone && !testPass && errorCount == 0, "R11 clear after done",
        {testDone, testPass, errorCount}, 0);

    // single outstanding read, start pulse mid-run ignored
    runTest("single_b8_poke", 8, 64, 0, 1, 0, -1, -1, 40);
    // limit not a multiple of the burst
    runTest("seq_b3_l30", 3, 30, 0, 0, 0, -1, -1, -1);
    // random addressing with auto precharge
    runTest("rand_b4_ap", 4, 256, 1, 0, 1, -1, -1, -1);
    // defaults selected by zero inputs
    runTest("defaults", 0, 0, 0, 0, 0, -1, -1, -1);
    chk(nTx == DEF_L / 4, "R14 default limit and burst", nTx, DEF_L / 4);

    // abort in the middle of a test
    startTest(4, 64, 0, 0, 1, -1, -1, -1);
    repeat (30) tick();
    @(negedge clk); clearPulse = 1'b1; memReadValid = 1'b0;
    @(negedge clk); clearPulse = 1'b0;
    #1;
    chk(!memRead && !memWrite && !memAutoPrecharge, "R11 clear stops requests",
        {memRead, memWrite}, 0);
    chk(!testDone && errorCount == 0, "R11 clear mid test", {testDone, errorCount}, 0);
    phase = 0;
    respQ.delete();
    outstanding = 0;
    // clean restart after abort
    runTest("restart_b2", 2, 16, 0, 0, 0, -1, -1, -1);
    chk(testDone && testPass, "R10 restart after clear", {testDone, testPass}, 2'b11);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule